// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block turns an asynchronous serial line into buffered characters. A baud generator outside the block supplies a tick at sixteen times the bit rate. On each tick the receiver looks at the line, finds a falling edge and confirms it at mid-bit. It then takes every following bit as a vote of three samples around the bit centre. The frame has 5 to 9 data bits, sent least significant bit first, an optional parity bit and one stop bit.

Finished characters go into a two-entry first-in first-out buffer. Each entry carries its own framing, parity and overrun marks, so the flags at the read port always describe the character at the head. When the buffer is full, one more finished character waits in the shift stage. It is lost only if yet another start bit is accepted before software makes room. A filter mode for multi-drop buses discards every frame whose address marker is clear. Dropping the enable throws away all buffered and pending state.

Top module: `frame_rx_top`

## Requirements
- R1: `size_code` selects the data width: 000 gives 5 bits, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9 (the other codes act as 8). Data arrives LSB first. `rd_data` holds bits 7..0 with the unused upper bits zero. `rd_bit8` holds the ninth bit and is 0 for narrower frames.
- R2: `par_code` 00 or 01 means no parity bit is expected. 10 expects even parity over the data bits and 11 expects odd parity. `rd_perr` is 1 exactly when the received parity bit disagrees with the mode that was set when the character started.
- R3: A low line opens a frame only if the vote of samples 7, 8 and 9 of that bit is still low. Every other bit is the majority of samples 7, 8 and 9 out of 16, so the line may differ from the bit value outside that window.
- R4: `rd_ferr` is 1 when the single stop bit is sampled low and 0 when it is sampled high.
- R5: The buffer holds two characters and returns them in arrival order. `rx_done` is high while at least one is unread. A `rd_pop` pulse removes the head, and a pop with an empty buffer changes nothing.
- R6: A character that finishes while the buffer is full waits in the shift stage. It enters the buffer, unmarked, on the next pop, provided no new start bit was accepted first.
- R7: If a start bit is accepted while the buffer is full and a character waits in the shift stage, the waiting character is discarded. The next character to enter the buffer carries `rd_ovr` = 1. A pop before that start bit prevents the loss.
- R8: The framing, parity and overrun marks belong to their own character and appear at the read port while that character is at the head.
- R9: With `mp_mode` = 1, a frame whose marker bit is 0 never reaches the buffer. The marker is the ninth bit in 9-bit frames and the most significant data bit in narrower ones. Frames with the marker set are stored normally.
- R10: Dropping `rx_en` empties the buffer, discards the waiting character and any pending overrun mark, and abandons a frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receiver enable; low flushes all state |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| size_code | input | 3 | Data width code |
| par_code | input | 2 | Parity mode code |
| mp_mode | input | 1 | Keep only frames with the address marker set |
| rd_pop | input | 1 | Remove the head character |
| rd_data | output | 8 | Head character, bits 7..0 |
| rd_bit8 | output | 1 | Head character, ninth bit |
| rd_ferr | output | 1 | Head character had a low stop bit |
| rd_ovr | output | 1 | A character was lost before the head |
| rd_perr | output | 1 | Head character failed its parity check |
| rx_done | output | 1 | Buffer holds at least one character |

## Verification
The two functions that can meet are a pop from the full buffer and the acceptance of the start bit that would cause an overrun. The pop moves the waiting character into the buffer, while the start bit wants to throw it away. The bench fills the buffer and the shift stage, then sends another frame and pops once near the start of its start bit and, in a second run, once after its middle. The result is judged by whether the character that later enters the buffer carries the overrun mark and whether the waiting character survives in order.

// File: rtl/frx_pkg.sv
package frx_pkg;

    localparam int MAX_BITS = 9;
    localparam int OSR      = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    // One received character with its own status marks
    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                ferr;
        logic                perr;
    } char_t;

    // Character as it leaves the deframer
    typedef struct packed {
        char_t chr;
        logic  addr;
    } frame_t;

    // Character as it is stored in the buffer
    typedef struct packed {
        char_t chr;
        logic  ovr;
    } entry_t;

    function automatic logic [3:0] size_of(input logic [2:0] code);
        case (code)
            3'b000:  return 4'd5;
            3'b001:  return 4'd6;
            3'b010:  return 4'd7;
            3'b111:  return 4'd9;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/frx_deframer.sv
module frx_deframer
    import frx_pkg::*;
#(
    parameter int OSR_P = OSR
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic       rxd,
    input  logic [2:0] size_code,
    input  logic [1:0] par_code,
    output logic       start_ok,
    output logic       frm_valid,
    output frame_t     frm_out
);
    localparam int CW  = $clog2(OSR_P);
    localparam int MID = OSR_P / 2;
    localparam logic [CW-1:0] SMP_A = CW'(MID - 1);
    localparam logic [CW-1:0] SMP_B = CW'(MID);
    localparam logic [CW-1:0] SMP_C = CW'(MID + 1);
    localparam logic [CW-1:0] SMP_E = CW'(OSR_P - 1);

    rx_state_e           state;
    logic [CW-1:0]       cnt;
    logic [1:0]          vote;
    logic [3:0]          bit_idx;
    logic [3:0]          nbits;
    logic                par_on;
    logic                par_odd;
    logic                par_rx;
    logic [MAX_BITS-1:0] shreg;
    logic                bit_val;
    logic [3:0]          last_idx;

    // third sample is the live line value
    assign bit_val  = maj3(vote[0], vote[1], rxd);
    assign last_idx = nbits - 4'd1;

    always_ff @(posedge clk) begin
        start_ok  <= 1'b0;
        frm_valid <= 1'b0;
        if (rst || !en) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            vote    <= '0;
            bit_idx <= '0;
            nbits   <= 4'd8;
            par_on  <= 1'b0;
            par_odd <= 1'b0;
            par_rx  <= 1'b0;
            shreg   <= '0;
            frm_out <= '0;
        end else if (tick) begin
            if (state == ST_IDLE) begin
                if (!rxd) begin
                    // this tick is sample 0 of the start bit
                    state   <= ST_START;
                    cnt     <= CW'(1);
                    shreg   <= '0;
                    bit_idx <= '0;
                    nbits   <= size_of(size_code);
                    par_on  <= par_code[1];
                    par_odd <= par_code[0];
                end
            end else begin
                cnt <= (cnt == SMP_E) ? '0 : cnt + CW'(1);
                if (cnt == SMP_A) vote[0] <= rxd;
                if (cnt == SMP_B) vote[1] <= rxd;
                if (cnt == SMP_C) begin
                    case (state)
                        ST_START: begin
                            if (bit_val) state <= ST_IDLE;
                            else         start_ok <= 1'b1;
                        end
                        ST_DATA: shreg[bit_idx] <= bit_val;
                        ST_PAR:  par_rx <= bit_val;
                        ST_STOP: begin
                            frm_valid         <= 1'b1;
                            frm_out.chr.data  <= shreg;
                            frm_out.addr      <= shreg[last_idx];
                            frm_out.chr.ferr  <= !bit_val;
                            frm_out.chr.perr  <= par_on & ((^shreg) ^ par_rx ^ par_odd);
                            state             <= ST_IDLE;
                        end
                        default: ;
                    endcase
                end
                if (cnt == SMP_E) begin
                    case (state)
                        ST_START: begin
                            state   <= ST_DATA;
                            bit_idx <= '0;
                        end
                        ST_DATA: begin
                            if (bit_idx == last_idx) state <= par_on ? ST_PAR : ST_STOP;
                            else                     bit_idx <= bit_idx + 4'd1;
                        end
                        ST_PAR:  state <= ST_STOP;
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/frx_rxbuf.sv
module frx_rxbuf
    import frx_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  entry_t           push_entry,
    input  logic             pop,
    output entry_t           head,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    entry_t        slot [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic          do_pop;
    logic          do_push;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign do_push = push && (!full || do_pop);
    assign head    = slot[rp];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                                slot[i] <= '0;
            else if (do_push && (wp == PW'(i)))     slot[i] <= push_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

endmodule

// File: rtl/frame_rx_top.sv
module frame_rx_top
    import frx_pkg::*;
#(
    parameter int OSR_P     = OSR,
    parameter int BUF_DEPTH = 2,
    localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [2:0] size_code,
    input  logic [1:0] par_code,
    input  logic       mp_mode,
    input  logic       rd_pop,
    output logic [7:0] rd_data,
    output logic       rd_bit8,
    output logic       rd_ferr,
    output logic       rd_ovr,
    output logic       rd_perr,
    output logic       rx_done
);
    logic             start_ok;
    logic             frm_valid;
    frame_t           frm;
    logic             accept;
    logic             pop_eff;
    logic             hold_v;
    char_t            hold;
    logic             lost_q;
    logic             push;
    entry_t           push_e;
    entry_t           head;
    logic [CNT_W-1:0] buf_cnt;
    logic             buf_full;

    frx_deframer #(.OSR_P(OSR_P)) u_deframer (
        .clk       (clk),
        .rst       (rst),
        .en        (rx_en),
        .tick      (tick16),
        .rxd       (rxd),
        .size_code (size_code),
        .par_code  (par_code),
        .start_ok  (start_ok),
        .frm_valid (frm_valid),
        .frm_out   (frm)
    );

    frx_rxbuf #(.DEPTH(BUF_DEPTH)) u_rxbuf (
        .clk        (clk),
        .rst        (rst),
        .flush      (!rx_en),
        .push       (push),
        .push_entry (push_e),
        .pop        (pop_eff),
        .head       (head),
        .count      (buf_cnt),
        .full       (buf_full)
    );

    assign rx_done = (buf_cnt != '0);
    assign pop_eff = rd_pop && rx_done;
    assign accept  = frm_valid && (!mp_mode || frm.addr);

    // the waiting character has priority; a fresh frame can never meet it
    always_comb begin
        push   = 1'b0;
        push_e = '0;
        if (hold_v && pop_eff) begin
            push   = 1'b1;
            push_e = '{chr: hold, ovr: lost_q};
        end else if (accept && (!buf_full || pop_eff)) begin
            push   = 1'b1;
            push_e = '{chr: frm.chr, ovr: lost_q};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            hold_v <= 1'b0;
            hold   <= '0;
            lost_q <= 1'b0;
        end else begin
            if (push) lost_q <= 1'b0;
            if (hold_v && pop_eff) begin
                hold_v <= 1'b0;
            end else if (hold_v && start_ok) begin
                hold_v <= 1'b0;
                lost_q <= 1'b1;
            end
            if (accept && buf_full && !pop_eff) begin
                hold_v <= 1'b1;
                hold   <= frm.chr;
            end
        end
    end

    assign rd_data = head.chr.data[7:0];
    assign rd_bit8 = head.chr.data[MAX_BITS-1];
    assign rd_ferr = head.chr.ferr;
    assign rd_perr = head.chr.perr;
    assign rd_ovr  = head.ovr;

endmodule

// File: rtl/frx_chk.sv
module frx_chk #(
    parameter int DEPTH = 2,
    parameter int CW    = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_en,
    input logic          rx_done,
    input logic          rd_pop,
    input logic [CW-1:0] buf_cnt,
    input logic          hold_v,
    input logic          lost_q,
    input logic          start_ok,
    input logic          frm_valid,
    input logic          frm_addr,
    input logic          mp_mode,
    input logic          push
);
    // R10
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!rx_done && !hold_v && !lost_q));

    // R5
    depth_chk: assert property (@(posedge clk) disable iff (rst)
        buf_cnt <= CW'(DEPTH));

    // R5
    pop_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rd_pop && (buf_cnt == CW'(1)) && !push) |=> !rx_done);

    // R6
    hold_full_chk: assert property (@(posedge clk) disable iff (rst)
        hold_v |-> (buf_cnt == CW'(DEPTH)));

    // R7
    lost_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lost_q) |-> ($past(hold_v) && $past(start_ok)));

    // R9
    mp_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && mp_mode && !frm_addr) |-> !push);
endmodule

bind frame_rx_top frx_chk #(.DEPTH(BUF_DEPTH), .CW(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_en     (rx_en),
    .rx_done   (rx_done),
    .rd_pop    (rd_pop),
    .buf_cnt   (buf_cnt),
    .hold_v    (hold_v),
    .lost_q    (lost_q),
    .start_ok  (start_ok),
    .frm_valid (frm_valid),
    .frm_addr  (frm.addr),
    .mp_mode   (mp_mode),
    .push      (push)
);

// File: tb/frame_rx_top_tb_top.sv
module frame_rx_top_tb_top;
    localparam int DIV     = 3;
    localparam int BIT_CLK = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0;
    logic       tick16;
    logic       rxd = 1'b1;
    logic [2:0] size_code = 3'b011;
    logic [1:0] par_code = 2'b00;
    logic       mp_mode = 1'b0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit8, rd_ferr, rd_ovr, rd_perr, rx_done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [1:0] divc = '0;

    always #10 clk = ~clk;

    always @(posedge clk) divc <= (divc == 2'(DIV - 1)) ? 2'd0 : divc + 2'd1;
    assign tick16 = (divc == 2'd0);

    frame_rx_top dut_i (
        .clk(clk), .rst(rst), .rx_en(rx_en), .tick16(tick16), .rxd(rxd),
        .size_code(size_code), .par_code(par_code), .mp_mode(mp_mode),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_bit8(rd_bit8), .rd_ferr(rd_ferr),
        .rd_ovr(rd_ovr), .rd_perr(rd_perr), .rx_done(rx_done)
    );

    function automatic int bits_of(input int code);
        case (code)
            0: return 5;
            1: return 6;
            2: return 7;
            7: return 9;
            default: return 8;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // pop_at: clock inside the start bit where one pop pulse is issued (-1: none)
    // noisy: data bits wrong outside the sampling window
    task automatic send(input int d, input int code, input int par, input int stop_v,
                        input int bad_par, input int pop_at, input int noisy);
        int n;
        int mask;
        int p;
        n = bits_of(code);
        mask = (1 << n) - 1;
        size_code = 3'(code);
        par_code = 2'(par);
        for (int c = 0; c < BIT_CLK; c++) begin
            rxd = 1'b0;
            rd_pop = (c == pop_at);
            @(negedge clk);
        end
        rd_pop = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic v;
            v = 1'((d >> i) & 1);
            if (noisy != 0) begin
                rxd = !v; clocks(15);
                rxd = v;  clocks(21);
                rxd = !v; clocks(12);
            end else begin
                rxd = v; clocks(BIT_CLK);
            end
        end
        if (par >= 2) begin
            p = ($countones(d & mask) & 1) ^ (par & 1) ^ bad_par;
            rxd = 1'(p);
            clocks(BIT_CLK);
        end
        rxd = 1'(stop_v);
        clocks(BIT_CLK);
        rxd = 1'b1;
        clocks(2 * BIT_CLK);
    endtask

    task automatic read(input string tag, input int d, input int code,
                        input int ferr, input int perr, input int ovr);
        int n;
        n = bits_of(code);
        chk({tag, " rx_done"}, int'(rx_done), 1);
        chk({tag, " data"}, int'(rd_data), d & ((1 << n) - 1) & 8'hFF);
        chk({tag, " bit8"}, int'(rd_bit8), (n == 9) ? ((d >> 8) & 1) : 0);
        chk({tag, " ferr"}, int'(rd_ferr), ferr);
        chk({tag, " perr"}, int'(rd_perr), perr);
        chk({tag, " ovr"}, int'(rd_ovr), ovr);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int codes[5] = '{0, 1, 2, 3, 7};
        clocks(5);
        rst = 1'b0;
        @(negedge clk);
        chk("reset rx_done R5", int'(rx_done), 0);
        rx_en = 1'b1;
        clocks(2 * BIT_CLK);

        // sweep of sizes, parity modes and patterns (R1, R2)
        for (int ci = 0; ci < 5; ci++) begin
            for (int pm = 0; pm < 4; pm++) begin
                for (int k = 0; k < 4; k++) begin
                    int d;
                    d = (k == 0) ? 0 : (k == 1) ? 9'h1FF : (k == 2) ? 9'h0A5 : ((ci * 53 + pm * 29 + 7) & 9'h1FF);
                    send(d, codes[ci], pm, 1, 0, -1, 0);
                    read("R1 R2 sweep", d, codes[ci], 0, 0, 0);
                    chk("R5 empty after pop", int'(rx_done), 0);
                end
            end
        end

        // parity errors (R2)
        send(8'h3C, 3, 2, 1, 1, -1, 0);
        read("R2 even bad", 8'h3C, 3, 0, 1, 0);
        send(9'h14D, 7, 3, 1, 1, -1, 0);
        read("R2 odd bad", 9'h14D, 7, 0, 1, 0);

        // framing error (R4)
        send(8'h5A, 3, 0, 0, 0, -1, 0);
        read("R4 low stop", 8'h5A, 3, 1, 0, 0);

        // start glitch then a clean frame (R3)
        rxd = 1'b0; clocks(12);
        rxd = 1'b1; clocks(3 * BIT_CLK);
        chk("R3 glitch ignored", int'(rx_done), 0);
        send(8'h96, 3, 0, 1, 0, -1, 1);
        read("R3 noisy bits", 8'h96, 3, 0, 0, 0);

        // pop on empty ignored (R5)
        rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0; @(negedge clk);
        chk("R5 pop empty", int'(rx_done), 0);
        send(8'h11, 3, 0, 1, 0, -1, 0);
        send(8'h22, 3, 0, 1, 0, -1, 0);
        read("R5 order first", 8'h11, 3, 0, 0, 0);
        read("R5 order second", 8'h22, 3, 0, 0, 0);
        chk("R5 drained", int'(rx_done), 0);

        // flags per character (R8)
        send(8'h0F, 3, 2, 0, 1, -1, 0);
        send(8'hF0, 3, 2, 1, 0, -1, 0);
        read("R8 flagged head", 8'h0F, 3, 1, 1, 0);
        read("R8 clean follower", 8'hF0, 3, 0, 0, 0);

        // third character waits and survives (R6)
        send(8'hA1, 3, 0, 1, 0, -1, 0);
        send(8'hA2, 3, 0, 1, 0, -1, 0);
        send(8'hA3, 3, 0, 1, 0, -1, 0);
        read("R6 a", 8'hA1, 3, 0, 0, 0);
        read("R6 b", 8'hA2, 3, 0, 0, 0);
        read("R6 held", 8'hA3, 3, 0, 0, 0);
        chk("R6 drained", int'(rx_done), 0);

        // overrun by a fourth start bit (R7)
        send(8'hB1, 3, 0, 1, 0, -1, 0);
        send(8'hB2, 3, 0, 1, 0, -1, 0);
        send(8'hB3, 3, 0, 1, 0, -1, 0);
        send(8'hB4, 3, 0, 1, 0, -1, 0);
        read("R7 a", 8'hB1, 3, 0, 0, 0);
        read("R7 b", 8'hB2, 3, 0, 0, 0);
        read("R7 after loss", 8'hB4, 3, 0, 0, 1);
        chk("R7 drained", int'(rx_done), 0);

        // pop early in the start bit prevents the loss (R7)
        send(8'hC1, 3, 0, 1, 0, -1, 0);
        send(8'hC2, 3, 0, 1, 0, -1, 0);
        send(8'hC3, 3, 0, 1, 0, -1, 0);
        send(8'hC4, 3, 0, 1, 0, 1, 0);
        read("R7 early pop b", 8'hC2, 3, 0, 0, 0);
        read("R7 early pop c", 8'hC3, 3, 0, 0, 0);
        read("R7 early pop d", 8'hC4, 3, 0, 0, 0);
        chk("R7 early drained", int'(rx_done), 0);

        // pop late in the start bit comes too late (R7)
        send(8'hD1, 3, 0, 1, 0, -1, 0);
        send(8'hD2, 3, 0, 1, 0, -1, 0);
        send(8'hD3, 3, 0, 1, 0, -1, 0);
        send(8'hD4, 3, 0, 1, 0, 40, 0);
        read("R7 late pop b", 8'hD2, 3, 0, 0, 0);
        read("R7 late pop d", 8'hD4, 3, 0, 0, 1);
        chk("R7 late drained", int'(rx_done), 0);

        // address filter (R9)
        mp_mode = 1'b1;
        send(9'h0F3, 7, 0, 1, 0, -1, 0);
        chk("R9 9-bit data dropped", int'(rx_done), 0);
        send(9'h1F3, 7, 0, 1, 0, -1, 0);
        read("R9 9-bit address kept", 9'h1F3, 7, 0, 0, 0);
        send(8'h05, 3, 0, 1, 0, -1, 0);
        chk("R9 8-bit data dropped", int'(rx_done), 0);
        send(8'h85, 3, 0, 1, 0, -1, 0);
        read("R9 8-bit address kept", 8'h85, 3, 0, 0, 0);
        mp_mode = 1'b0;

        // flush (R10)
        send(8'hE1, 3, 0, 1, 0, -1, 0);
        chk("R10 before flush", int'(rx_done), 1);
        rx_en = 1'b0; @(negedge clk); rx_en = 1'b1; @(negedge clk);
        chk("R10 after flush", int'(rx_done), 0);
        send(8'hE2, 3, 0, 1, 0, -1, 0);
        send(8'hE3, 3, 0, 1, 0, -1, 0);
        send(8'hE4, 3, 0, 1, 0, -1, 0);
        send(8'hE5, 3, 0, 1, 0, -1, 0);
        rx_en = 1'b0; @(negedge clk); rx_en = 1'b1; @(negedge clk);
        chk("R10 flush full", int'(rx_done), 0);
        send(8'hE6, 3, 0, 1, 0, -1, 0);
        read("R10 mark cleared", 8'hE6, 3, 0, 0, 0);
        chk("R10 nothing held", int'(rx_done), 0);
        // frame abandoned mid-way
        size_code = 3'b011; par_code = 2'b00;
        rxd = 1'b0; clocks(3 * BIT_CLK);
        rx_en = 1'b0; @(negedge clk); rx_en = 1'b1;
        rxd = 1'b1; clocks(12 * BIT_CLK);
        chk("R10 abandoned frame", int'(rx_done), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule